// File: doc/BRIEF.md
# Tracking Converter Step Controller

This block is the digital half of a tracking analog-to-digital converter. It owns an up/down code register that feeds an external DAC. The analog side compares the DAC output with the input and reports the result on two comparator lines. `cmp_above` means the input is more than half an LSB above the DAC output. `cmp_below` means it is more than half an LSB below it. The controller moves the code one step per clock toward the input. When neither line is asserted it freezes the code and raises `data_ready`.

A sticky `new_data` flag lets a reader poll the converter and fetch the code only after it has actually moved. The flag is raised on the first ready cycle after a period in which the code changed. A single-cycle `read_ack` clears it.

The comparator lines can pass through a parameterised synchroniser. The default is two flops for comparators that run asynchronously to `clk`. Setting the depth to zero suits comparators clocked from the same clock, and then the loop settles without dither.

Top module: `trk_adc_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the code with mid-scale, 2^(WIDTH-1) (2048 for 12 bits), and clears `new_data` and every synchroniser flop.
- R2: While both synchronised comparator lines are low, the code holds its value and `data_ready` is 1.
- R3: While only `cmp_above` is high (synchronised), the code rises by exactly 1 per clock. While only `cmp_below` is high, it falls by exactly 1 per clock.
- R4: While both synchronised comparator lines are high, an illegal state, the code holds and `data_ready` is 0.
- R5: With SYNC_STAGES = S, a comparator value sampled at rising edge k reaches `data_ready` just after edge k+S-1 and moves the code at edge k+S. With S = 2, a change driven before edge 1 shows on `data_ready` after edge 2 and on the code after edge 3.
- R6: The code saturates: it stays at 2^WIDTH-1 while counting up and at 0 while counting down, and never wraps.
- R7: `new_data` rises one clock after the first ready cycle that follows a cycle in which the code changed. Ready periods with no code change in between, including a step blocked by saturation, do not set it.
- R8: `read_ack` high at a rising edge clears `new_data`. If a set and a clear fall on the same edge, `new_data` ends up 1.
- R9: In a closed loop with S = 0 and an input that moves at most 1 LSB per clock, the code stays within ±1 LSB of the input. Once the input is constant, the code stops changing.
- R10: In a closed loop with S = 0, acquiring an input N codes away takes exactly N clocks. That is at most 2^WIDTH clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_above | input | 1 | Input exceeds DAC output by more than half an LSB |
| cmp_below | input | 1 | Input is below DAC output by more than half an LSB |
| read_ack | input | 1 | Reader has taken the code; clears `new_data` |
| code | output | WIDTH | Code driving the DAC and read as the conversion result |
| data_ready | output | 1 | Code lies within the half-LSB window |
| new_data | output | 1 | Sticky flag: the code has moved and settled since the last read |

## Verification
The bench goes after the synchroniser latency. A design with the wrong number of stages moves the code one edge early or late, and it overshoots by a different amount after the comparator drops. It drives the code into both rails for far longer than a full sweep. A wrapping counter would jump from full scale to zero there, or from zero to full scale. It stalls against a rail and holds the illegal both-high state to confirm that neither raises `new_data`. A flag set on every ready cycle, or one tied to the comparator rather than to real movement, would fail those checks. It also lands `read_ack` on the very edge that sets the flag, where a clear-priority design loses the notification. A closed analog model then checks exact acquisition time, ±1 LSB ramp tracking and zero code activity on a settled input.

// File: rtl/trk_pkg.sv
package trk_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'b00,
      ACT_UP    = 2'b01,
      ACT_DOWN  = 2'b10,
      ACT_FAULT = 2'b11
   } trk_act_e;
endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES:0] chain;
         assign chain[0] = d;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) chain[i+1] <= 1'b0;
               else     chain[i+1] <= chain[i];
            end
         end
         assign q = chain[STAGES];
      end
   endgenerate
endmodule

// File: rtl/trk_decide.sv
module trk_decide
   import trk_pkg::*;
(
   input  logic     up_req,
   input  logic     dn_req,
   output trk_act_e act,
   output logic     ready
);
   always_comb begin
      unique case ({dn_req, up_req})
         2'b00:   act = ACT_HOLD;
         2'b01:   act = ACT_UP;
         2'b10:   act = ACT_DOWN;
         default: act = ACT_FAULT;
      endcase
   end
   assign ready = (act == ACT_HOLD);
endmodule

// File: rtl/trk_counter.sv
module trk_counter
   import trk_pkg::*;
#(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  trk_act_e         act,
   output logic [WIDTH-1:0] code,
   output logic             step_en
);
   localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] CODE_MID = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] code_q;

   assign step_en = ((act == ACT_UP)   && (code_q != CODE_MAX)) ||
                    ((act == ACT_DOWN) && (code_q != '0));

   always_ff @(posedge clk) begin
      if (rst)          code_q <= CODE_MID;
      else if (step_en) code_q <= (act == ACT_UP) ? code_q + 1'b1 : code_q - 1'b1;
   end

   assign code = code_q;

   // R3
   step_size_chk: assert property (@(posedge clk) disable iff (rst)
      (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1) ||
      (code_q == $past(code_q) - 1'b1));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_HOLD) |=> $stable(code_q));

   // R4
   fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_FAULT) |=> $stable(code_q));

   // R6
   sat_top_chk: assert property (@(posedge clk) disable iff (rst)
      (code_q == CODE_MAX && act == ACT_UP) |=> (code_q == CODE_MAX));

   // R6
   sat_bottom_chk: assert property (@(posedge clk) disable iff (rst)
      (code_q == '0 && act == ACT_DOWN) |=> (code_q == '0));
endmodule

// File: rtl/trk_flags.sv
module trk_flags (
   input  logic clk,
   input  logic rst,
   input  logic ready,
   input  logic step_en,
   input  logic read_ack,
   output logic new_data
);
   logic moved_q;
   logic new_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         moved_q <= 1'b0;
         new_q   <= 1'b0;
      end else begin
         moved_q <= ready ? 1'b0 : (moved_q | step_en);
         new_q   <= (ready & moved_q) | (new_q & ~read_ack);
      end
   end

   assign new_data = new_q;

   // R7
   rise_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(new_q) |-> $past(ready));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (ready && moved_q && read_ack) |=> new_q);

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (read_ack && !(ready && moved_q)) |=> !new_q);
endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
   import trk_pkg::*;
#(
   parameter int WIDTH       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmp_above,
   input  logic             cmp_below,
   input  logic             read_ack,
   output logic [WIDTH-1:0] code,
   output logic             data_ready,
   output logic             new_data
);
   generate
      if (WIDTH < 2 || WIDTH > 24) begin : g_bad_width
         $error("trk_adc_ctrl: WIDTH must lie in 2..24");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("trk_adc_ctrl: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic     up_s;
   logic     dn_s;
   trk_act_e act;
   logic     ready;
   logic     step_en;

   trk_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
      .clk(clk), .rst(rst), .d(cmp_above), .q(up_s));

   trk_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
      .clk(clk), .rst(rst), .d(cmp_below), .q(dn_s));

   trk_decide u_decide (
      .up_req(up_s), .dn_req(dn_s), .act(act), .ready(ready));

   trk_counter #(.WIDTH(WIDTH)) u_counter (
      .clk(clk), .rst(rst), .act(act), .code(code), .step_en(step_en));

   trk_flags u_flags (
      .clk(clk), .rst(rst), .ready(ready), .step_en(step_en),
      .read_ack(read_ack), .new_data(new_data));

   assign data_ready = ready;

   // R2
   ready_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      data_ready |=> $stable(code));
endmodule

// File: tb/trk_adc_ctrl_bench.sv
module trk_adc_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 12;
   localparam int MID        = 1 << (W - 1);
   localparam int TOP        = (1 << W) - 1;
   localparam int WDOG       = 150000;

   logic clk = 1'b0;
   logic rst = 1'b1;

   logic         d_above = 1'b0;
   logic         d_below = 1'b0;
   logic         d_ack   = 1'b0;
   logic [W-1:0] d_code;
   logic         d_ready;
   logic         d_new;

   int           tgt2 = 2 * MID;
   int           l_err;
   logic         l_above;
   logic         l_below;
   logic [W-1:0] l_code;
   logic         l_ready;
   logic         l_new;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   trk_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) u_trk_adc_ctrl (
      .clk(clk), .rst(rst), .cmp_above(d_above), .cmp_below(d_below),
      .read_ack(d_ack), .code(d_code), .data_ready(d_ready), .new_data(d_new));

   // behavioural analog loop: input and DAC in half-LSB units
   assign l_err   = tgt2 - 2 * int'(l_code);
   assign l_above = (l_err > 1);
   assign l_below = (l_err < -1);

   trk_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(0)) u_trk_adc_ctrl_loop (
      .clk(clk), .rst(rst), .cmp_above(l_above), .cmp_below(l_below),
      .read_ack(1'b0), .code(l_code), .data_ready(l_ready), .new_data(l_new));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack_pulse();
      d_ack = 1'b1;
      ticks(1);
      d_ack = 1'b0;
   endtask

   task automatic t_reset();
      check(d_code == MID, "R1 code after reset", d_code, MID);
      check(d_new == 1'b0, "R1 new_data after reset", d_new, 0);
      check(d_ready == 1'b1, "R2 ready after reset", d_ready, 1);
   endtask

   task automatic t_idle();
      ticks(20);
      check(d_code == MID, "R2 idle hold", d_code, MID);
      check(d_new == 1'b0, "R7 idle no flag", d_new, 0);
   endtask

   task automatic t_up_latency();
      d_above = 1'b1;
      ticks(1);
      check(d_code == MID && d_ready, "R5 after edge 1", d_code, MID);
      ticks(1);
      check(d_ready == 1'b0, "R5 ready drops after edge 2", d_ready, 0);
      check(d_code == MID, "R5 code still held after edge 2", d_code, MID);
      ticks(1);
      check(d_code == MID + 1, "R5 first step after edge 3", d_code, MID + 1);
      ticks(7);
      check(d_code == MID + 8, "R3 up one per clock", d_code, MID + 8);
      d_above = 1'b0;
      ticks(2);
      check(d_code == MID + 10, "R5 overshoot of pipeline", d_code, MID + 10);
      check(d_ready == 1'b1, "R2 ready after release", d_ready, 1);
      check(d_new == 1'b0, "R7 flag not yet", d_new, 0);
      ticks(1);
      check(d_new == 1'b1, "R7 flag one clock after ready", d_new, 1);
      ticks(5);
      check(d_code == MID + 10, "R2 hold after settle", d_code, MID + 10);
   endtask

   task automatic t_ack();
      ack_pulse();
      check(d_new == 1'b0, "R8 ack clears", d_new, 0);
      ticks(5);
      check(d_new == 1'b0, "R7 no re-set without move", d_new, 0);
   endtask

   task automatic t_down_collision();
      d_below = 1'b1;
      ticks(12);
      check(d_code == MID, "R3 down one per clock", d_code, MID);
      d_below = 1'b0;
      ticks(2);
      check(d_code == MID - 2, "R3 down after release", d_code, MID - 2);
      d_ack = 1'b1;
      ticks(1);
      d_ack = 1'b0;
      check(d_new == 1'b1, "R8 set wins over ack", d_new, 1);
      ack_pulse();
      check(d_new == 1'b0, "R8 later ack clears", d_new, 0);
   endtask

   task automatic t_fault();
      d_above = 1'b1;
      d_below = 1'b1;
      ticks(2);
      check(d_ready == 1'b0, "R4 fault not ready", d_ready, 0);
      ticks(10);
      check(d_code == MID - 2, "R4 fault holds code", d_code, MID - 2);
      d_above = 1'b0;
      d_below = 1'b0;
      ticks(2);
      check(d_ready == 1'b1, "R2 ready after fault", d_ready, 1);
      ticks(1);
      check(d_new == 1'b0, "R7 fault does not set flag", d_new, 0);
   endtask

   task automatic t_saturate();
      d_above = 1'b1;
      ticks(2200);
      check(d_code == TOP, "R6 saturates at top", d_code, TOP);
      check(d_ready == 1'b0, "R3 not ready while pushing up", d_ready, 0);
      d_above = 1'b0;
      ticks(3);
      check(d_new == 1'b1, "R7 flag after climb", d_new, 1);
      ack_pulse();
      d_above = 1'b1;
      ticks(20);
      check(d_code == TOP, "R6 stays at top", d_code, TOP);
      d_above = 1'b0;
      ticks(3);
      check(d_new == 1'b0, "R7 blocked step sets no flag", d_new, 0);
      d_below = 1'b1;
      ticks(4200);
      check(d_code == 0, "R6 saturates at zero", d_code, 0);
      d_below = 1'b0;
      ticks(3);
      check(d_new == 1'b1, "R7 flag after descent", d_new, 1);
      ack_pulse();
      d_below = 1'b1;
      ticks(20);
      check(d_code == 0, "R6 stays at zero", d_code, 0);
      d_below = 1'b0;
      ticks(3);
   endtask

   task automatic t_loop_acquire();
      int n;
      check(l_code == MID && l_new == 1'b0, "R9 loop idle at start", l_code, MID);
      tgt2 = 2 * 4000;
      n = 0;
      while (!(l_ready && l_code == 4000) && n < 5000) begin
         ticks(1);
         n++;
      end
      check(n == 4000 - MID, "R10 acquisition clocks", n, 4000 - MID);
      check(n <= (1 << W), "R10 within full-scale bound", n, 1 << W);
      ticks(1);
      check(l_new == 1'b1, "R7 loop flag after acquire", l_new, 1);
   endtask

   task automatic t_loop_ramp();
      int bad;
      int worst;
      bad = 0;
      worst = 0;
      for (int i = 0; i < 1000; i++) begin
         tgt2 = tgt2 - 2;
         ticks(1);
         if (l_err > 2 || l_err < -2) begin
            bad++;
            worst = l_err;
         end
      end
      check(bad == 0, "R9 fast ramp within 1 LSB", worst, 0);
      bad = 0;
      for (int i = 0; i < 600; i++) begin
         tgt2 = tgt2 + 1;
         ticks(1);
         if (l_err > 2 || l_err < -2) begin
            bad++;
            worst = l_err;
         end
      end
      check(bad == 0, "R9 slow ramp within 1 LSB", worst, 0);
   endtask

   task automatic t_loop_stable();
      int changes;
      logic [W-1:0] last;
      tgt2 = 2 * 3210 + 1;
      ticks(200);
      last = l_code;
      changes = 0;
      for (int i = 0; i < 300; i++) begin
         ticks(1);
         if (l_code != last) changes++;
         last = l_code;
      end
      check(changes == 0, "R9 settled input gives no code change", changes, 0);
      check(l_ready == 1'b1, "R9 ready on settled input", l_ready, 1);
      check(l_code == 3210 || l_code == 3211, "R9 settled code within window",
            l_code, 3210);
   endtask

   initial begin
      ticks(3);
      rst = 1'b0;
      ticks(1);
      t_reset();
      t_idle();
      t_up_latency();
      t_ack();
      t_down_collision();
      t_fault();
      t_saturate();
      t_loop_acquire();
      t_loop_ramp();
      t_loop_stable();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", WDOG, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule